// File: doc/BRIEF.md
# Branch-Target Cache with Fetch Redirect

This block sits beside the fetch stage of a pipeline. Each cycle the fetch unit presents the address it is fetching. The block compares that address against a small direct-mapped table of branches that are expected to be taken. On an exact match it returns the remembered destination in the same cycle, so fetch can jump there on the next cycle. On no match, fetch continues at the next sequential word.

Later in the pipeline, a resolve port reports the outcome of each instruction. It gives the instruction address, whether the instruction turned out to be a taken branch, and the computed destination. The block checks that address against its own table. A taken branch that was missing is filled in. A stored entry whose instruction was not taken is removed. Both of these cases raise a two-cycle stall:

- In the first cycle the table is rewritten and lookups are ignored.
- In the second cycle a redirect tells fetch where to restart.

A correct hit, or a miss on an instruction that is not taken, costs nothing. Only branches whose destination is fixed relative to their own address are expected on the resolve port, so a stored destination never goes stale.

Top module: `branch_target_cache`

## Requirements
- R1: After reset every table entry is invalid, `stall` and `redirect_valid` are low, and every lookup misses.
- R2: With no hit, `pred_hit` is 0 and `pred_next_pc` equals `fetch_pc + 4`. When `fetch_valid` is 0, `pred_hit` is 0.
- R3: A hit needs all 32 bits of `fetch_pc` to equal the stored instruction address. The table slot is `fetch_pc[4:2]`. An address that differs in any other bit, including bits [1:0] or bit 31, misses. A later fill to the same slot replaces the earlier entry.
- R4: On a hit, in the same cycle as the lookup, `pred_hit` is 1 and `pred_next_pc` is the stored destination.
- R5: A resolve that misses in the table and reports taken fills the slot with the address and destination. It causes a stall, and the redirect carries the reported destination.
- R6: A resolve that hits in the table and reports not taken invalidates the entry. It causes a stall, and the redirect carries the resolve address + 4.
- R7: A resolve that hits and reports taken, or misses and reports not taken, raises no stall and no redirect, and leaves the table unchanged.
- R8: A stall lasts exactly two cycles, starting the cycle after the resolve. `redirect_valid` is low in the first cycle and high in the second, with `redirect_pc` set.
- R9: In the first stall cycle, lookups are ignored: `pred_hit` is 0 and `pred_next_pc` is `fetch_pc + 4`.
- R10: A resolve presented while `stall` is high has no effect on the table or the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch address is presented this cycle |
| fetch_pc | input | 32 | Address being fetched |
| pred_hit | output | 1 | Exact match found; fetch should jump |
| pred_next_pc | output | 32 | Next fetch address (stored destination or sequential) |
| rsv_valid | input | 1 | Resolve report present |
| rsv_pc | input | 32 | Address of the resolved instruction |
| rsv_taken | input | 1 | Instruction was a taken branch |
| rsv_target | input | 32 | Computed branch destination |
| stall | output | 1 | Penalty window, two cycles |
| redirect_valid | output | 1 | Restart fetch at redirect_pc (second penalty cycle) |
| redirect_pc | output | 32 | Corrected fetch address |

## Verification
The bench sweeps sixteen branch addresses through six rounds of mixed taken and not-taken outcomes, each pair of addresses sharing a slot. After every step it looks up each address, its slot alias, and two near-miss addresses that differ only in bit 31 or bit 0. A design that compared only part of the address would redirect on these near misses. A design that did not replace on slot conflict would return the wrong destination. Each penalty window is sampled cycle by cycle. Doing so catches a stall of one or three cycles, a redirect in the wrong cycle, a lookup that answers during the rewrite, and a resolve injected mid-stall that wrongly allocates an entry.

// File: rtl/btc_pkg.sv
package btc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_REWRITE = 2'd1,
        PH_RESTART = 2'd2
    } phase_e;
endpackage

// File: rtl/btc_table.sv
module btc_table #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 3,
    parameter int unsigned OFF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_fill,
    input  logic [PC_W-1:0]  wr_pc,
    input  logic [PC_W-1:0]  wr_tgt,
    input  logic [PC_W-1:0]  a_pc,
    output logic             a_vld,
    output logic [PC_W-1:0]  a_epc,
    output logic [PC_W-1:0]  a_tgt,
    input  logic [PC_W-1:0]  b_pc,
    output logic             b_vld,
    output logic [PC_W-1:0]  b_epc
);
    localparam int unsigned N    = 1 << IDX_W;
    localparam int unsigned HI_W = PC_W - IDX_W - OFF_W;
    localparam int unsigned IHI  = OFF_W + IDX_W - 1;

    typedef struct packed {
        logic             vld;
        logic [HI_W-1:0]  hi;
        logic [OFF_W-1:0] lo;
        logic [PC_W-1:0]  tgt;
    } ent_t;

    ent_t tab_q [N];
    ent_t tab_d [N];
    logic [IDX_W-1:0] w_idx, a_idx, b_idx;
    ent_t a_ent, b_ent;

    assign w_idx = wr_pc[IHI:OFF_W];
    assign a_idx = a_pc[IHI:OFF_W];
    assign b_idx = b_pc[IHI:OFF_W];

    always_comb begin
        for (int e = 0; e < N; e++) tab_d[e] = tab_q[e];
        if (wr_en) begin
            tab_d[w_idx].vld = wr_fill;
            tab_d[w_idx].hi  = wr_pc[PC_W-1:IHI+1];
            tab_d[w_idx].lo  = wr_pc[OFF_W-1:0];
            tab_d[w_idx].tgt = wr_tgt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < N; e++) tab_q[e] <= '0;
        end else begin
            for (int e = 0; e < N; e++) tab_q[e] <= tab_d[e];
        end
    end

    assign a_ent = tab_q[a_idx];
    assign b_ent = tab_q[b_idx];
    assign a_vld = a_ent.vld;
    assign a_epc = {a_ent.hi, a_idx, a_ent.lo};
    assign a_tgt = a_ent.tgt;
    assign b_vld = b_ent.vld;
    assign b_epc = {b_ent.hi, b_idx, b_ent.lo};
endmodule

// File: rtl/btc_probe.sv
module btc_probe #(
    parameter int unsigned PC_W = 32
) (
    input  logic            req,
    input  logic [PC_W-1:0] pc,
    input  logic            ent_vld,
    input  logic [PC_W-1:0] ent_pc,
    output logic            hit
);
    // full-address compare: a partial match must never count
    assign hit = req && ent_vld && (ent_pc == pc);
endmodule

// File: rtl/btc_penalty.sv
module btc_penalty #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned OFF_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rsv_valid,
    input  logic [PC_W-1:0] rsv_pc,
    input  logic            rsv_taken,
    input  logic [PC_W-1:0] rsv_target,
    input  logic            rsv_hit,
    output logic            stall,
    output logic            lookup_block,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc,
    output logic            wr_en,
    output logic            wr_fill,
    output logic [PC_W-1:0] wr_pc,
    output logic [PC_W-1:0] wr_tgt
);
    import btc_pkg::*;

    localparam logic [PC_W-1:0] STEP = PC_W'(1) << OFF_W;

    typedef struct packed {
        phase_e          ph;
        logic            fill;
        logic [PC_W-1:0] pc;
        logic [PC_W-1:0] tgt;
        logic [PC_W-1:0] rpc;
    } pen_t;

    pen_t s_d, s_q;
    logic accept;

    always_comb begin
        s_d    = s_q;
        accept = rsv_valid && (s_q.ph == PH_IDLE);
        case (s_q.ph)
            PH_IDLE: begin
                if (accept && rsv_hit && !rsv_taken) begin
                    s_d.ph   = PH_REWRITE;
                    s_d.fill = 1'b0;
                    s_d.pc   = rsv_pc;
                    s_d.tgt  = rsv_target;
                    s_d.rpc  = rsv_pc + STEP;
                end else if (accept && !rsv_hit && rsv_taken) begin
                    s_d.ph   = PH_REWRITE;
                    s_d.fill = 1'b1;
                    s_d.pc   = rsv_pc;
                    s_d.tgt  = rsv_target;
                    s_d.rpc  = rsv_target;
                end
            end
            PH_REWRITE: s_d.ph = PH_RESTART;
            PH_RESTART: s_d.ph = PH_IDLE;
            default:    s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE, fill: 1'b0, pc: '0, tgt: '0, rpc: '0};
        else        s_q <= s_d;
    end

    assign stall          = (s_q.ph != PH_IDLE);
    assign lookup_block   = (s_q.ph == PH_REWRITE);
    assign wr_en          = (s_q.ph == PH_REWRITE);
    assign wr_fill        = s_q.fill;
    assign wr_pc          = s_q.pc;
    assign wr_tgt         = s_q.tgt;
    assign redirect_valid = (s_q.ph == PH_RESTART);
    assign redirect_pc    = s_q.rpc;
endmodule

// File: rtl/branch_target_cache.sv
module branch_target_cache #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 3,
    parameter int unsigned OFF_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_valid,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_hit,
    output logic [PC_W-1:0] pred_next_pc,
    input  logic            rsv_valid,
    input  logic [PC_W-1:0] rsv_pc,
    input  logic            rsv_taken,
    input  logic [PC_W-1:0] rsv_target,
    output logic            stall,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(1) << OFF_W;

    logic            a_vld, b_vld, a_hit, b_hit, lookup_block;
    logic [PC_W-1:0] a_epc, a_tgt, b_epc;
    logic            wr_en, wr_fill;
    logic [PC_W-1:0] wr_pc, wr_tgt;

    btc_table #(.PC_W(PC_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_fill(wr_fill), .wr_pc(wr_pc), .wr_tgt(wr_tgt),
        .a_pc(fetch_pc), .a_vld(a_vld), .a_epc(a_epc), .a_tgt(a_tgt),
        .b_pc(rsv_pc), .b_vld(b_vld), .b_epc(b_epc)
    );

    btc_probe #(.PC_W(PC_W)) u_fetch_probe (
        .req(fetch_valid && !lookup_block), .pc(fetch_pc),
        .ent_vld(a_vld), .ent_pc(a_epc), .hit(a_hit)
    );

    btc_probe #(.PC_W(PC_W)) u_resolve_probe (
        .req(rsv_valid), .pc(rsv_pc),
        .ent_vld(b_vld), .ent_pc(b_epc), .hit(b_hit)
    );

    btc_penalty #(.PC_W(PC_W), .OFF_W(OFF_W)) u_penalty (
        .clk(clk), .rst_n(rst_n),
        .rsv_valid(rsv_valid), .rsv_pc(rsv_pc), .rsv_taken(rsv_taken),
        .rsv_target(rsv_target), .rsv_hit(b_hit),
        .stall(stall), .lookup_block(lookup_block),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .wr_en(wr_en), .wr_fill(wr_fill), .wr_pc(wr_pc), .wr_tgt(wr_tgt)
    );

    assign pred_hit     = a_hit;
    assign pred_next_pc = a_hit ? a_tgt : fetch_pc + STEP;
endmodule

module btc_checker (
    input logic clk,
    input logic rst_n,
    input logic fetch_valid,
    input logic pred_hit,
    input logic rsv_valid,
    input logic stall,
    input logic redirect_valid
);
    assert_hit_needs_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pred_hit |-> fetch_valid);

    assert_stall_second_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |=> stall);

    assert_stall_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && $past(stall)) |=> !stall);

    assert_redirect_late_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (stall && $past(stall)));

    assert_rewrite_blind_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !redirect_valid) |-> !pred_hit);

    assert_stall_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(rsv_valid));

    assert_no_extend_R10: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !stall);
endmodule

bind branch_target_cache btc_checker u_btc_checker (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .pred_hit(pred_hit),
    .rsv_valid(rsv_valid), .stall(stall), .redirect_valid(redirect_valid)
);

// File: tb/test_branch_target_cache.sv
`timescale 1ns/1ps
module test_branch_target_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_hit;
    logic [31:0] pred_next_pc;
    logic        rsv_valid = 1'b0;
    logic [31:0] rsv_pc = '0;
    logic        rsv_taken = 1'b0;
    logic [31:0] rsv_target = '0;
    logic        stall, redirect_valid;
    logic [31:0] redirect_pc;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    bit          mv  [8];
    logic [31:0] mpc [8];
    logic [31:0] mtg [8];

    always #2.5 clk = ~clk;

    branch_target_cache i_branch_target_cache (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .pred_hit(pred_hit), .pred_next_pc(pred_next_pc),
        .rsv_valid(rsv_valid), .rsv_pc(rsv_pc), .rsv_taken(rsv_taken),
        .rsv_target(rsv_target), .stall(stall), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit model_hit(input logic [31:0] pc);
        return mv[pc[4:2]] && (mpc[pc[4:2]] == pc);
    endfunction

    task automatic lookup(input logic [31:0] pc, input string req);
        bit eh;
        logic [31:0] en;
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_pc = pc;
        #1;
        eh = model_hit(pc);
        en = eh ? mtg[pc[4:2]] : pc + 32'd4;
        chk(pred_hit == eh, eh ? "R4 hit" : req, {31'd0, pred_hit}, {31'd0, eh});
        chk(pred_next_pc == en, eh ? "R4 next" : "R2 next", pred_next_pc, en);
    endtask

    task automatic resolve(input logic [31:0] pc, input bit tk, input logic [31:0] tg, input bit poke);
        int i;
        bit hit, pen;
        logic [31:0] rp;
        logic [31:0] ppc;
        i = int'(pc[4:2]);
        hit = model_hit(pc);
        pen = (hit && !tk) || (!hit && tk);
        rp = tk ? tg : pc + 32'd4;
        ppc = 32'h0000_9F00;
        @(negedge clk);
        fetch_valid = 1'b0;
        rsv_valid = 1'b1; rsv_pc = pc; rsv_taken = tk; rsv_target = tg;
        #1 chk(stall == 1'b0, "R8 idle before", {31'd0, stall}, 32'd0);
        @(negedge clk);
        rsv_valid = 1'b0;
        #1;
        if (pen) begin
            chk(stall == 1'b1, tk ? "R5 stall" : "R6 stall", {31'd0, stall}, 32'd1);
            chk(redirect_valid == 1'b0, "R8 no redirect first", {31'd0, redirect_valid}, 32'd0);
            fetch_valid = 1'b1; fetch_pc = pc;
            if (poke) begin
                rsv_valid = 1'b1; rsv_pc = ppc; rsv_taken = 1'b1; rsv_target = 32'h0003_3330;
            end
            #1;
            chk(pred_hit == 1'b0, "R9 blind hit", {31'd0, pred_hit}, 32'd0);
            chk(pred_next_pc == pc + 32'd4, "R9 blind next", pred_next_pc, pc + 32'd4);
            @(negedge clk);
            rsv_valid = 1'b0; fetch_valid = 1'b0;
            #1;
            chk(stall == 1'b1, "R8 second stall", {31'd0, stall}, 32'd1);
            chk(redirect_valid == 1'b1, "R8 redirect", {31'd0, redirect_valid}, 32'd1);
            chk(redirect_pc == rp, tk ? "R5 redirect pc" : "R6 redirect pc", redirect_pc, rp);
            @(negedge clk);
            #1;
            chk(stall == 1'b0, "R8 end", {31'd0, stall}, 32'd0);
            chk(redirect_valid == 1'b0, "R8 end redirect", {31'd0, redirect_valid}, 32'd0);
            if (tk) begin mv[i] = 1'b1; mpc[i] = pc; mtg[i] = tg; end
            else    mv[i] = 1'b0;
            if (poke) lookup(ppc, "R10 ignored resolve");
        end else begin
            chk(stall == 1'b0, "R7 no stall", {31'd0, stall}, 32'd0);
            chk(redirect_valid == 1'b0, "R7 no redirect", {31'd0, redirect_valid}, 32'd0);
        end
    endtask

    initial begin
        logic [31:0] pcs [16];
        for (int j = 0; j < 8; j++) begin mv[j] = 1'b0; mpc[j] = '0; mtg[j] = '0; end
        for (int j = 0; j < 16; j++) pcs[j] = 32'h0000_4000 + 32'(j % 8) * 4 + 32'(j / 8) * 32'h40;
        repeat (3) @(negedge clk);
        #1;
        chk(stall == 1'b0, "R1 reset stall", {31'd0, stall}, 32'd0);
        chk(redirect_valid == 1'b0, "R1 reset redirect", {31'd0, redirect_valid}, 32'd0);
        rst_n = 1'b1;
        for (int j = 0; j < 16; j++) lookup(pcs[j], "R1 empty");
        // fetch_valid low masks a would-be hit
        resolve(pcs[3], 1'b1, 32'h0002_0030, 1'b0);
        @(negedge clk);
        fetch_valid = 1'b0; fetch_pc = pcs[3];
        #1 chk(pred_hit == 1'b0, "R2 no fetch", {31'd0, pred_hit}, 32'd0);
        for (int r = 0; r < 6; r++) begin
            for (int j = 0; j < 16; j++) begin
                bit tk;
                tk = ((j * 7 + r * 3) % 5) < 3;
                resolve(pcs[j], tk, 32'h0002_0000 + 32'(j) * 32'h10 + 32'(r) * 32'h1000, j == 5);
                lookup(pcs[j], "R3 self");
                lookup(pcs[j ^ 8], "R3 alias");
                lookup(pcs[j] ^ 32'h8000_0000, "R3 top bit");
                lookup(pcs[j] ^ 32'h0000_0001, "R3 low bit");
            end
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule